// File: doc/BRIEF.md
# Radix-4 Parallel-Carry Word Adder

This block adds two unsigned words whose digits are base-4 values, each digit carried on a 2-bit bus holding 0 to 3. The words are split into four-digit groups. In every group, each digit position first adds its two operand digits and derives two binary flags from that partial sum: a generate flag and a propagate flag. All carries of the group are then formed in parallel from these flags and the incoming carry, as an OR of AND terms, without rippling through the digits. Each binary carry is taken as the digit value 1 and added to its position's partial sum. This gives the final digit.

The group carry-out feeds the carry-in of the next more significant group, so the default of two groups adds eight-digit words. A carry-in bit adds the digit value 1 at the least significant position. The carry-out bit reports that the full word sum reached 4 to the power of the digit count. The combinational result is captured in one output register stage, which exists for timing closure.

Top module: `qd_cla_adder`

## Requirements
- R1: A digit position's generate flag is 1 exactly when its two operand digits sum to more than 3.
- R2: A digit position's propagate flag is 1 exactly when its two operand digits sum to exactly 3. Generate and propagate are never both 1.
- R3: Within a group, the carry into digit i+1 equals generate(i) OR (propagate(i) AND carry into digit i), with the carry into digit 0 being the group's carry-in. The carries are computed as fully expanded product terms.
- R4: Each sum digit equals (a + b + carry) mod 4, where carry is the binary carry into that digit, taken as the value 0 or 1.
- R5: carry_out is 1 exactly when a + b + carry_in, read as base-4 integers, is at least 4 to the power of the total digit count.
- R6: carry_in = 1 adds one unit at the least significant digit.
- R7: The carry-out of each four-digit group is the carry-in of the next more significant group. Digit k of a word occupies bits [2k+1:2k], and digit 0 is the least significant.
- R8: The outputs are registered. sum_word and carry_out show the sum of the inputs sampled at the previous rising clock edge. While rst_n is low, both outputs are 0, whatever the inputs are.
- R9: The registered {carry_out, sum_word} equals the integer sum a_word + b_word + carry_in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset; release it synchronously |
| a_word | input | 16 | First operand, eight base-4 digits of 2 bits each |
| b_word | input | 16 | Second operand, eight base-4 digits of 2 bits each |
| carry_in | input | 1 | Incoming carry, digit value 0 or 1 |
| sum_word | output | 16 | Registered eight-digit sum |
| carry_out | output | 1 | Registered outgoing carry |

## Verification
The bench sweeps every pair of four-digit operands with both carry-in values, with the upper group held at zero. In that sweep a low-group carry-out must appear as a 1 in digit 4. A design that swapped generate and propagate, or compared the partial sum against 3 with the wrong bound, would corrupt the digits just above any position summing to 3 or to more than 3. Directed vectors set up a propagate chain across all eight digits from the carry-in, and also the all-ones and all-threes overflow cases. These expose a dropped product term, a broken link between the groups, or a carry that only ripples one position. Random eight-digit vectors check the group cascade, and a reset window with live inputs checks that the output register stays cleared.

// File: rtl/qd_pkg.sv
package qd_pkg;
  localparam int DIGIT_W = 2;
  localparam int RADIX   = 4;
  localparam int MAX_DIG = RADIX - 1;
  typedef logic [DIGIT_W-1:0] digit_t;
endpackage

// File: rtl/qd_half_add.sv
module qd_half_add
  import qd_pkg::*;
(
  input  digit_t x_dig,
  input  digit_t y_dig,
  output digit_t s_dig,
  output logic   c_bit
);
  logic [DIGIT_W:0] wide_sum;

  always_comb begin
    wide_sum = {1'b0, x_dig} + {1'b0, y_dig};
    s_dig    = wide_sum[DIGIT_W-1:0];
    c_bit    = wide_sum[DIGIT_W];
  end
endmodule

// File: rtl/qd_digit_gp.sv
module qd_digit_gp
  import qd_pkg::*;
(
  input  digit_t a_dig,
  input  digit_t b_dig,
  output digit_t part_dig,
  output logic   gen_f,
  output logic   prop_f
);
  logic hi_c;

  qd_half_add u_stage1 (
    .x_dig (a_dig),
    .y_dig (b_dig),
    .s_dig (part_dig),
    .c_bit (hi_c)
  );

  always_comb begin
    gen_f  = hi_c;
    prop_f = (~hi_c) & (part_dig == digit_t'(MAX_DIG));
  end

  always_comb begin
    if (!$isunknown({a_dig, b_dig})) begin
      // R1
      gen_thresh_chk: assert (gen_f == ((int'(a_dig) + int'(b_dig)) > MAX_DIG))
        else $error("generate flag wrong");
      // R2
      gp_excl_chk: assert (!(gen_f && prop_f))
        else $error("generate and propagate both set");
    end
  end
endmodule

// File: rtl/qd_carry_lookahead.sv
module qd_carry_lookahead #(
  parameter int NDIG = 4
) (
  input  logic [NDIG-1:0] gen_v,
  input  logic [NDIG-1:0] prop_v,
  input  logic            c_in,
  output logic [NDIG:0]   carry_v
);
  logic acc;
  logic term;

  always_comb begin
    carry_v[0] = c_in;
    for (int i = 0; i < NDIG; i++) begin
      term = c_in;
      for (int j = 0; j <= i; j++) term = term & prop_v[j];
      acc = term;
      for (int j = 0; j <= i; j++) begin
        term = gen_v[j];
        for (int k = j + 1; k <= i; k++) term = term & prop_v[k];
        acc = acc | term;
      end
      carry_v[i+1] = acc;
    end
  end

  for (genvar gi = 0; gi < NDIG; gi++) begin : g_rip
    always_comb begin
      if (!$isunknown({gen_v, prop_v, c_in})) begin
        // R3
        ripple_eq_chk: assert (carry_v[gi+1] == (gen_v[gi] | (prop_v[gi] & carry_v[gi])))
          else $error("lookahead carry differs from ripple recurrence");
      end
    end
  end
endmodule

// File: rtl/qd_group.sv
module qd_group
  import qd_pkg::*;
#(
  parameter int NDIG = 4,
  localparam int GW  = NDIG * DIGIT_W
) (
  input  logic [GW-1:0] a_grp,
  input  logic [GW-1:0] b_grp,
  input  logic          c_in,
  output logic [GW-1:0] s_grp,
  output logic          c_out
);
  logic [NDIG-1:0] gen_v;
  logic [NDIG-1:0] prop_v;
  logic [NDIG:0]   carry_v;
  logic [NDIG-1:0] spill_v;
  digit_t          part_d [NDIG];

  for (genvar d = 0; d < NDIG; d++) begin : g_dig
    digit_t a_d, b_d, s_d, c_d;
    assign a_d = a_grp[d*DIGIT_W +: DIGIT_W];
    assign b_d = b_grp[d*DIGIT_W +: DIGIT_W];
    assign c_d = digit_t'(carry_v[d]);

    qd_digit_gp u_gp (
      .a_dig    (a_d),
      .b_dig    (b_d),
      .part_dig (part_d[d]),
      .gen_f    (gen_v[d]),
      .prop_f   (prop_v[d])
    );

    qd_half_add u_stage2 (
      .x_dig (part_d[d]),
      .y_dig (c_d),
      .s_dig (s_d),
      .c_bit (spill_v[d])
    );

    assign s_grp[d*DIGIT_W +: DIGIT_W] = s_d;

    always_comb begin
      if (!$isunknown({a_d, b_d, carry_v[d]})) begin
        // R4
        digit_mod_chk: assert (int'(s_d) == ((int'(a_d) + int'(b_d) + int'(carry_v[d])) % RADIX))
          else $error("sum digit wrong");
        // R3
        spill_src_chk: assert (!spill_v[d] || (prop_v[d] && carry_v[d+1]))
          else $error("second stage overflow without propagate");
      end
    end
  end

  qd_carry_lookahead #(.NDIG(NDIG)) u_cla (
    .gen_v   (gen_v),
    .prop_v  (prop_v),
    .c_in    (c_in),
    .carry_v (carry_v)
  );

  assign c_out = carry_v[NDIG];
endmodule

// File: rtl/qd_cla_adder.sv
module qd_cla_adder
  import qd_pkg::*;
#(
  parameter int GRP_DIG = 4,
  parameter int NGRP    = 2,
  localparam int GW     = GRP_DIG * DIGIT_W,
  localparam int WW     = GW * NGRP
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [WW-1:0] a_word,
  input  logic [WW-1:0] b_word,
  input  logic          carry_in,
  output logic [WW-1:0] sum_word,
  output logic          carry_out
);
  logic [NGRP:0]   link_c;
  logic [WW-1:0]   sum_nxt;
  logic            cout_nxt;

  assign link_c[0] = carry_in;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    qd_group #(.NDIG(GRP_DIG)) u_grp (
      .a_grp (a_word[g*GW +: GW]),
      .b_grp (b_word[g*GW +: GW]),
      .c_in  (link_c[g]),
      .s_grp (sum_nxt[g*GW +: GW]),
      .c_out (link_c[g+1])
    );
  end

  assign cout_nxt = link_c[NGRP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_word  <= '0;
      carry_out <= 1'b0;
    end else begin
      sum_word  <= sum_nxt;
      carry_out <= cout_nxt;
    end
  end

  // R8
  reg_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ({carry_out, sum_word} == $past({cout_nxt, sum_nxt})))
    else $error("output register does not follow adder");

  // R9
  int_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown({a_word, b_word, carry_in}) |->
      ({cout_nxt, sum_nxt} == ({1'b0, a_word} + {1'b0, b_word} + {{WW{1'b0}}, carry_in})))
    else $error("word sum differs from integer sum");
endmodule

// File: tb/qd_cla_adder_test.sv
`timescale 1ns/1ps
module qd_cla_adder_test;
  localparam int WW = 16;

  typedef struct packed {
    logic [WW-1:0] s;
    logic          c;
    logic [3:0]    tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [WW-1:0] a_word, b_word;
  logic          carry_in;
  logic [WW-1:0] sum_word;
  logic          carry_out;

  exp_t exp_q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  always #2 clk = ~clk;

  qd_cla_adder uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_word    (a_word),
    .b_word    (b_word),
    .carry_in  (carry_in),
    .sum_word  (sum_word),
    .carry_out (carry_out)
  );

  function automatic string tname(logic [3:0] t);
    case (t)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  // driver: applies a vector at a falling edge and queues its expected result
  task automatic drive(input logic [WW-1:0] a, input logic [WW-1:0] b,
                       input logic ci, input logic [3:0] tag);
    logic [WW:0] tot;
    exp_t e;
    @(negedge clk);
    a_word   = a;
    b_word   = b;
    carry_in = ci;
    tot = {1'b0, a} + {1'b0, b} + {{WW{1'b0}}, ci};
    e.s   = tot[WW-1:0];
    e.c   = tot[WW];
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: the register loads at the rising edge, so compare just after it
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_chk++;
      if (sum_word !== e.s || carry_out !== e.c) begin
        n_fail++;
        $display("FAIL %s: got cout=%0b sum=%h expected cout=%0b sum=%h",
                 tname(e.tag), carry_out, sum_word, e.c, e.s);
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    a_word   = 16'hFFFF;
    b_word   = 16'h0001;
    carry_in = 1'b1;
    // R8: reset holds outputs at zero with live inputs
    repeat (3) begin
      @(negedge clk);
      n_chk++;
      if (sum_word !== '0 || carry_out !== 1'b0) begin
        n_fail++;
        $display("FAIL R8: got cout=%0b sum=%h expected cout=0 sum=0000", carry_out, sum_word);
      end
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1: digit sums above 3 generate
    drive(16'h0003, 16'h0003, 1'b0, 4'd1);
    drive(16'h0002, 16'h0002, 1'b0, 4'd1);
    // R2: digit sum exactly 3 only propagates
    drive(16'h0001, 16'h0002, 1'b0, 4'd2);
    drive(16'h0003, 16'h0000, 1'b1, 4'd2);
    // R3: long propagate chain fed by a low generate
    drive(16'h5557, 16'hAAA9, 1'b0, 4'd3);
    drive(16'h00FF, 16'h0000, 1'b1, 4'd3);
    // R4: mixed digits per position
    drive(16'h1B6C, 16'h2D93, 1'b1, 4'd4);
    // R5: overflow of the whole word
    drive(16'hFFFF, 16'hFFFF, 1'b1, 4'd5);
    drive(16'hFFFF, 16'h0000, 1'b1, 4'd5);
    drive(16'h8000, 16'h8000, 1'b0, 4'd5);
    // R6: carry-in alone
    drive(16'h0000, 16'h0000, 1'b1, 4'd6);
    // R7: low group carry crosses into high group
    drive(16'h00FF, 16'h0001, 1'b0, 4'd7);
    drive(16'h3300, 16'h00FF, 1'b1, 4'd7);

    // R9: exhaustive low group, both carry-in values
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        for (int c = 0; c < 2; c++)
          drive(16'(a), 16'(b), 1'(c), ((a + b + c) > 255) ? 4'd7 : 4'd9);

    // R9: random eight-digit vectors
    for (int r = 0; r < 3000; r++)
      drive(16'($urandom), 16'($urandom), 1'($urandom), 4'd9);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule